// File: doc/BRIEF.md
# Streaming Gradient Product Stage

This block sits at the front of a corner-detection pipeline. It takes a raster stream of 8-bit grayscale pixels, at most one per clock, marked by a valid strobe, a frame-start flag on the first pixel of a frame and a line-end flag on the last pixel of each row. Two row stores and a small shift chain of pixel columns give it a 3x3 neighbourhood around each centre pixel.

For each centre pixel it forms a horizontal and a vertical central difference. From these it produces three signed products, Ix·Ix, Iy·Iy and Ix·Iy, in the same output cycle. Each result carries the centre's column and row. Results whose centre lies on the frame border are marked with the valid flag low. The frame size is set by parameters (640 by 480 by default). Each pipeline step has its own register, so one result leaves per accepted pixel once the pipeline is full.

Top module: `grad_product_stage`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `out_stb` and `out_valid` are low.
- R2: An accepted pixel with `in_sof` high sits at column 0, row 0. After an accepted pixel with `in_eol` high, the next pixel starts column 0 of the next row. Otherwise the column advances by one per accepted pixel.
- R3: An accepted pixel at column c ≥ 1, row r ≥ 1 makes `out_stb` high on the second clock edge after the edge that accepts it, with `out_x` = c−1 and `out_y` = r−1. No other accepted pixel and no idle cycle makes a strobe, so centres in the final column and final row get no strobe.
- R4: `out_valid` is high only together with `out_stb`, and only when the centre lies in columns 1..IMG_W−2 and rows 1..IMG_H−2.
- R5: For a valid result at centre (x,y), Ix = p(x+1,y) − p(x−1,y) and Iy = p(x,y+1) − p(x,y−1), each a signed 9-bit value.
- R6: A valid result carries `out_ixx` = Ix·Ix, `out_iyy` = Iy·Iy and `out_ixy` = Ix·Iy, each an 18-bit two's-complement value, all from the same centre.
- R7: Cycles with `in_valid` low change neither the neighbourhood nor the position. Results match an unbroken stream apart from timing.
- R8: A frame start seen in the middle of a frame restarts the position at (0,0). The results of the new frame then depend only on its own pixels.
- R9: On a valid result, `out_ixx` and `out_iyy` are never negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eol | input | 1 | Pixel is the last of its row |
| in_pix | input | 8 | Grayscale pixel value |
| out_stb | output | 1 | A result is present |
| out_valid | output | 1 | Result centre is an interior pixel |
| out_x | output | $clog2(IMG_W) | Centre column |
| out_y | output | $clog2(IMG_H) | Centre row |
| out_ixx | output | 18 | Ix·Ix, signed |
| out_iyy | output | 18 | Iy·Iy, signed |
| out_ixy | output | 18 | Ix·Iy, signed |

## Verification
The hardest cases to reach are a frame start that arrives part way through a frame, and a stream with idle cycles. In both, the row stores and the column chain still hold data from earlier pixels that the new results must not use. The bench aborts a frame after two rows and at once starts a new one with a different pattern. It also runs frames with idle cycles placed at irregular pixel positions. In every run, each strobe is compared with values computed from a plain image array. One pattern uses blocks of 0 and 255 so that derivatives reach ±255 and the products reach their extremes.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int PIX_W = 8;
  localparam int DER_W = PIX_W + 1;
  localparam int PRD_W = 2 * DER_W;
  localparam int NTAP  = 3;

  typedef logic [PIX_W-1:0]        pix_t;
  typedef logic signed [DER_W-1:0] der_t;
  typedef logic signed [PRD_W-1:0] prd_t;

  typedef struct packed {
    pix_t top;
    pix_t mid;
    pix_t bot;
  } col_t;
endpackage

// File: rtl/gp_pos_track.sv
module gp_pos_track #(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  localparam int XW = $clog2(IMG_W),
  localparam int YW = $clog2(IMG_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eol,
  output logic [XW-1:0] cur_x,
  output logic [YW-1:0] cur_y
);
  logic [XW-1:0] xcnt_q, xcnt_d;
  logic [YW-1:0] ycnt_q, ycnt_d;

  always_comb begin
    cur_x  = in_sof ? '0 : xcnt_q;
    cur_y  = in_sof ? '0 : ycnt_q;
    xcnt_d = xcnt_q;
    ycnt_d = ycnt_q;
    if (in_valid) begin
      xcnt_d = in_eol ? '0 : cur_x + XW'(1);
      ycnt_d = in_eol ? cur_y + YW'(1) : cur_y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcnt_q <= '0;
      ycnt_q <= '0;
    end else if (in_valid) begin
      xcnt_q <= xcnt_d;
      ycnt_q <= ycnt_d;
    end
  end

  // R2
  sof_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !in_eol) |=> (xcnt_q == XW'(1) && ycnt_q == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(xcnt_q) && $stable(ycnt_q)));
endmodule

// File: rtl/gp_window.sv
module gp_window
  import gp_pkg::*;
#(
  parameter int IMG_W = 640,
  localparam int XW = $clog2(IMG_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [XW-1:0] cur_x,
  input  pix_t          pix,
  output col_t          col_new,
  output col_t          col_mid,
  output col_t          col_old
);
  pix_t row_up1 [IMG_W];
  pix_t row_up2 [IMG_W];
  col_t incoming;
  col_t taps [NTAP];

  always_comb begin
    incoming.top = row_up2[cur_x];
    incoming.mid = row_up1[cur_x];
    incoming.bot = pix;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      row_up2[cur_x] <= row_up1[cur_x];
      row_up1[cur_x] <= pix;
    end
  end

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    col_t tap_d;
    always_comb tap_d = (i == 0) ? incoming : taps[(i == 0) ? 0 : i-1];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  taps[i] <= '0;
      else if (en) taps[i] <= tap_d;
    end
  end

  assign col_new = taps[0];
  assign col_mid = taps[1];
  assign col_old = taps[2];

  // R7
  taps_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(taps[0]));
endmodule

// File: rtl/gp_deriv_mult.sv
module gp_deriv_mult
  import gp_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_in,
  input  logic          ok_in,
  input  logic [XW-1:0] x_in,
  input  logic [YW-1:0] y_in,
  input  col_t          col_new,
  input  col_t          col_mid,
  input  col_t          col_old,
  output logic          stb_out,
  output logic          ok_out,
  output logic [XW-1:0] x_out,
  output logic [YW-1:0] y_out,
  output prd_t          ixx,
  output prd_t          iyy,
  output prd_t          ixy
);
  der_t ix_d, iy_d, ix_q, iy_q;
  logic stb_q, ok_q;
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  prd_t ixx_d, iyy_d, ixy_d;

  always_comb begin
    ix_d  = der_t'({1'b0, col_new.mid}) - der_t'({1'b0, col_old.mid});
    iy_d  = der_t'({1'b0, col_mid.bot}) - der_t'({1'b0, col_mid.top});
    ixx_d = ix_q * ix_q;
    iyy_d = iy_q * iy_q;
    ixy_d = ix_q * iy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      stb_q <= stb_in;
      ok_q  <= stb_in & ok_in;
    end
  end

  always_ff @(posedge clk) begin
    if (stb_in) begin
      ix_q <= ix_d;
      iy_q <= iy_d;
      x_q  <= x_in;
      y_q  <= y_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_out <= 1'b0;
      ok_out  <= 1'b0;
    end else begin
      stb_out <= stb_q;
      ok_out  <= ok_q;
    end
  end

  always_ff @(posedge clk) begin
    if (stb_q) begin
      ixx   <= ixx_d;
      iyy   <= iyy_d;
      ixy   <= ixy_d;
      x_out <= x_q;
      y_out <= y_q;
    end
  end

  // R9
  sq_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_out |-> (!ixx[PRD_W-1] && !iyy[PRD_W-1]));
endmodule

// File: rtl/grad_product_stage.sv
module grad_product_stage
  import gp_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  localparam int XW = $clog2(IMG_W),
  localparam int YW = $clog2(IMG_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eol,
  input  logic [7:0]        in_pix,
  output logic              out_stb,
  output logic              out_valid,
  output logic [XW-1:0]     out_x,
  output logic [YW-1:0]     out_y,
  output logic signed [17:0] out_ixx,
  output logic signed [17:0] out_iyy,
  output logic signed [17:0] out_ixy
);
  localparam logic [XW-1:0] X_LAST = XW'(IMG_W - 2);
  localparam logic [YW-1:0] Y_LAST = YW'(IMG_H - 2);

  logic [XW-1:0] cur_x, cen_x, s1_x;
  logic [YW-1:0] cur_y, cen_y, s1_y;
  logic          s1_stb_d, s1_ok_d, s1_stb, s1_ok;
  col_t          c_new, c_mid, c_old;
  prd_t          p_xx, p_yy, p_xy;

  gp_pos_track #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_pos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eol(in_eol), .cur_x(cur_x), .cur_y(cur_y)
  );

  gp_window #(.IMG_W(IMG_W)) u_win (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .cur_x(cur_x), .pix(in_pix),
    .col_new(c_new), .col_mid(c_mid), .col_old(c_old)
  );

  always_comb begin
    cen_x    = cur_x - XW'(1);
    cen_y    = cur_y - YW'(1);
    s1_stb_d = in_valid && (cur_x != '0) && (cur_y != '0);
    s1_ok_d  = (cen_x != '0) && (cen_x <= X_LAST) &&
               (cen_y != '0) && (cen_y <= Y_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_stb <= 1'b0;
      s1_ok  <= 1'b0;
    end else begin
      s1_stb <= s1_stb_d;
      s1_ok  <= s1_stb_d & s1_ok_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_stb_d) begin
      s1_x <= cen_x;
      s1_y <= cen_y;
    end
  end

  gp_deriv_mult #(.XW(XW), .YW(YW)) u_dm (
    .clk(clk), .rst_n(rst_n), .stb_in(s1_stb), .ok_in(s1_ok),
    .x_in(s1_x), .y_in(s1_y),
    .col_new(c_new), .col_mid(c_mid), .col_old(c_old),
    .stb_out(out_stb), .ok_out(out_valid), .x_out(out_x), .y_out(out_y),
    .ixx(p_xx), .iyy(p_yy), .ixy(p_xy)
  );

  assign out_ixx = p_xx;
  assign out_iyy = p_yy;
  assign out_ixy = p_xy;

  // R3
  stb_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb |-> $past(in_valid, 3));

  // R4
  valid_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_stb);

  // R4
  interior_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_x != '0 && out_x <= X_LAST && out_y != '0 && out_y <= Y_LAST));
endmodule

// File: tb/sim_grad_product_stage.sv
module sim_grad_product_stage;
  localparam int CLK_P = 10;
  localparam int W = 6;
  localparam int H = 5;
  localparam int XW = $clog2(W);
  localparam int YW = $clog2(H);

  logic clk = 1'b0;
  logic rst_n, in_valid, in_sof, in_eol;
  logic [7:0] in_pix;
  logic out_stb, out_valid;
  logic [XW-1:0] out_x;
  logic [YW-1:0] out_y;
  logic signed [17:0] out_ixx, out_iyy, out_ixy;

  int checks = 0;
  int errors = 0;
  int img [H][W];
  int bx = 0, by = 0;
  int h_stb [3], h_ok [3], h_x [3], h_y [3], h_xx [3], h_yy [3], h_xy [3];

  always #(CLK_P/2) clk = ~clk;

  grad_product_stage #(.IMG_W(W), .IMG_H(H)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eol(in_eol), .in_pix(in_pix), .out_stb(out_stb), .out_valid(out_valid),
    .out_x(out_x), .out_y(out_y), .out_ixx(out_ixx), .out_iyy(out_iyy),
    .out_ixy(out_ixy)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pat_pix(int pat, int x, int y);
    case (pat)
      0:       return (x * 3 + y * 7) & 255;
      1:       return (x * 37 + y * 101 + x * y * 13) & 255;
      2:       return (((x / 2) + (y / 2)) & 1) ? 255 : 0;
      default: return 200 - x * 11 - y * 29;
    endcase
  endfunction

  task automatic step(bit v, bit sof, bit eol, int p);
    int px, py, cx, cy, ix, iy;
    @(negedge clk);
    // R3 strobe timing and coordinates, R4 border flag
    chk("R3 strobe", int'(out_stb), h_stb[2]);
    if (!out_stb) chk("R4 valid without strobe", int'(out_valid), 0);
    if (h_stb[2] != 0 && out_stb) begin
      chk("R3 out_x", int'(out_x), h_x[2]);
      chk("R3 out_y", int'(out_y), h_y[2]);
      chk("R4 valid", int'(out_valid), h_ok[2]);
      if (h_ok[2] != 0) begin
        // R5 derivatives seen through R6 products
        chk("R6 ixx", int'(out_ixx), h_xx[2]);
        chk("R6 iyy", int'(out_iyy), h_yy[2]);
        chk("R5 ixy", int'(out_ixy), h_xy[2]);
      end
    end
    for (int k = 2; k > 0; k--) begin
      h_stb[k] = h_stb[k-1]; h_ok[k] = h_ok[k-1]; h_x[k] = h_x[k-1];
      h_y[k] = h_y[k-1]; h_xx[k] = h_xx[k-1]; h_yy[k] = h_yy[k-1];
      h_xy[k] = h_xy[k-1];
    end
    h_stb[0] = 0; h_ok[0] = 0; h_x[0] = 0; h_y[0] = 0;
    h_xx[0] = 0; h_yy[0] = 0; h_xy[0] = 0;
    if (v) begin
      // R2 position model
      px = sof ? 0 : bx;
      py = sof ? 0 : by;
      if (px < W && py < H) img[py][px] = p;
      if (px >= 1 && py >= 1) begin
        cx = px - 1; cy = py - 1;
        h_stb[0] = 1; h_x[0] = cx; h_y[0] = cy;
        if (cx >= 1 && cx <= W - 2 && cy >= 1 && cy <= H - 2) begin
          h_ok[0] = 1;
          ix = img[cy][cx+1] - img[cy][cx-1];
          iy = img[cy+1][cx] - img[cy-1][cx];
          h_xx[0] = ix * ix; h_yy[0] = iy * iy; h_xy[0] = ix * iy;
        end
      end
      bx = eol ? 0 : px + 1;
      by = eol ? py + 1 : py;
    end
    in_valid = v; in_sof = v & sof; in_eol = v & eol;
    in_pix = v ? 8'(p) : 8'hA5;
  endtask

  task automatic frame(int pat, bit gaps, int rows);
    for (int y = 0; y < rows; y++) begin
      for (int x = 0; x < W; x++) begin
        // R7 idle cycles at irregular positions
        if (gaps && ((x * 5 + y) % 3 == 0)) step(1'b0, 1'b0, 1'b0, 0);
        step(1'b1, (x == 0 && y == 0), (x == W - 1), pat_pix(pat, x, y));
      end
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      h_stb[k] = 0; h_ok[k] = 0; h_x[k] = 0; h_y[k] = 0;
      h_xx[k] = 0; h_yy[k] = 0; h_xy[k] = 0;
    end
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_pix = '0;
    repeat (3) @(negedge clk);
    // R1 outputs idle during reset
    chk("R1 strobe in reset", int'(out_stb), 0);
    chk("R1 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobe after release", int'(out_stb), 0);
    chk("R1 valid after release", int'(out_valid), 0);

    for (int pat = 0; pat < 4; pat++) begin
      frame(pat, 1'b0, H);
      flush();
    end
    // R7 same patterns with idle cycles inside the stream
    for (int pat = 0; pat < 4; pat++) begin
      frame(pat, 1'b1, H);
      flush();
    end
    // R8 abort after two rows, restart with a new frame at once
    frame(1, 1'b0, 2);
    frame(2, 1'b0, H);
    flush();
    frame(0, 1'b1, 3);
    frame(3, 1'b1, H);
    flush();
    // back-to-back frames with no idle between
    frame(2, 1'b0, H);
    frame(1, 1'b0, H);
    flush();
    finish_run();
  end
endmodule